// File: doc/BRIEF.md
# Split-Row Min Combiner and Message Selector

This block is the back end of one check-node row in a layered offset min-sum decoder whose block columns are divided between two serial minimum finders. Each finder reports, for its own half of the row, the smallest and second-smallest magnitude, the position of the smallest, and the XOR of the signs it saw. The block merges the two reports into an exact full-row summary with two comparisons, so a decoder split in this way decodes exactly as an unsplit one. It then turns each stored temporary value T of the row into a new check message R and a new variable message Q.

The block has three streams, each using valid/ready. A row summary is accepted only when no row is held. The summary is then registered once and reused for every element of that row. The summary is released when the element marked last is accepted. Elements are accepted only while a row is held and the one-deep output register is empty or being drained in the same cycle. An output held under back-pressure keeps its values unchanged. Each stream transfers on a rising clock edge where valid and ready are both high.

Top module: `split_row_combiner`

## Requirements
- R1: After reset, out_valid and elem_ready are low and row_ready is high.
- R2: The full-row first minimum is the smaller of the two half first minima. The half that supplies it is the winner, with half A (half code 0) winning ties. Half B has half code 1.
- R3: The full-row second minimum is the smaller of the loser's first minimum and the winner's second minimum. This equals the second-smallest of the four reported magnitudes.
- R4: The full-row sign is the XOR of the two half signs, where 1 means negative.
- R5: An element whose half code and position both equal the winner's half and first-minimum position uses the second minimum. Every other element uses the first minimum.
- R6: The magnitude of R is the selected minimum minus 1, floored at 0. R is negative exactly when the full-row sign XOR the MSB of T is 1, and R is a 5-bit two's-complement value.
- R7: Q equals T + R, saturated to the 5-bit two's-complement range [-16, 15] instead of wrapping.
- R8: row_ready is low from the cycle after a summary is accepted until the element flagged last has been accepted. Every element in between uses that one summary.
- R9: elem_ready is low whenever the output holds a result that is not being taken (out_valid high, out_ready low). A result not taken keeps out_r, out_q and out_last stable.
- R10: Results leave in element order, one per accepted element, and out_last repeats the element's last flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_valid | input | 1 | Row summary offered |
| row_ready | output | 1 | Row summary can be taken (no row held) |
| a_m1 | input | 4 | Half A smallest magnitude |
| a_m2 | input | 4 | Half A second-smallest magnitude |
| a_idx | input | 3 | Half A position of smallest |
| a_sign | input | 1 | Half A sign parity |
| b_m1 | input | 4 | Half B smallest magnitude |
| b_m2 | input | 4 | Half B second-smallest magnitude |
| b_idx | input | 3 | Half B position of smallest |
| b_sign | input | 1 | Half B sign parity |
| elem_valid | input | 1 | Element offered |
| elem_ready | output | 1 | Element can be taken |
| elem_t | input | 5 | Temporary value T, two's complement |
| elem_half | input | 1 | Element half code (0 = A, 1 = B) |
| elem_pos | input | 3 | Element position within its half |
| elem_last | input | 1 | Last element of the row |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result consumer ready |
| out_r | output | 5 | New check message |
| out_q | output | 5 | New variable message, saturated |
| out_last | output | 1 | Last result of the row |

## Verification
The bench builds the block with its default values: 5-bit messages, 3-bit positions and an offset of 1. With these values T can sit at both rails of the 5-bit range, so both saturation limits of Q are reached. Minima of 0 and 1 reach the zero floor of the offset. Directed rows cover both winners, equal first minima, and the two cases of whether the loser's first minimum or the winner's second minimum becomes the second minimum. A few hundred random rows then run under a throttled output ready, which exercises the stall and hold rules.

// File: rtl/rowcmb_pkg.sv
package rowcmb_pkg;
  localparam int MSG_W = 5;
  localparam int MAG_W = MSG_W - 1;
  localparam int POS_W = 3;

  typedef struct packed {
    logic [MAG_W-1:0] m1;
    logic [MAG_W-1:0] m2;
    logic [POS_W-1:0] idx;
    logic             half;
    logic             sgn;
  } row_sum_t;
endpackage

// File: rtl/rowcmb_merge.sv
module rowcmb_merge
  import rowcmb_pkg::*;
(
  input  logic [MAG_W-1:0] a_m1,
  input  logic [MAG_W-1:0] a_m2,
  input  logic [POS_W-1:0] a_idx,
  input  logic             a_sign,
  input  logic [MAG_W-1:0] b_m1,
  input  logic [MAG_W-1:0] b_m2,
  input  logic [POS_W-1:0] b_idx,
  input  logic             b_sign,
  output row_sum_t         merged
);
  logic             a_wins;
  logic [MAG_W-1:0] lose_m1;
  logic [MAG_W-1:0] win_m2;

  always_comb begin
    a_wins      = (a_m1 <= b_m1);
    lose_m1     = a_wins ? b_m1 : a_m1;
    win_m2      = a_wins ? a_m2 : b_m2;
    merged.m1   = a_wins ? a_m1 : b_m1;
    merged.m2   = (lose_m1 < win_m2) ? lose_m1 : win_m2;
    merged.idx  = a_wins ? a_idx : b_idx;
    merged.half = ~a_wins;
    merged.sgn  = a_sign ^ b_sign;
  end
endmodule

// File: rtl/rowcmb_satadd.sv
module rowcmb_satadd
  import rowcmb_pkg::*;
(
  input  logic [MSG_W-1:0] op_a,
  input  logic [MSG_W-1:0] op_b,
  output logic [MSG_W-1:0] sum_sat
);
  localparam logic [MSG_W-1:0] MAX_V = {1'b0, {(MSG_W-1){1'b1}}};
  localparam logic [MSG_W-1:0] MIN_V = {1'b1, {(MSG_W-1){1'b0}}};

  logic [MSG_W:0] wide;
  logic           ovf;

  always_comb begin
    wide    = {op_a[MSG_W-1], op_a} + {op_b[MSG_W-1], op_b};
    ovf     = wide[MSG_W] ^ wide[MSG_W-1];
    sum_sat = ovf ? (wide[MSG_W] ? MIN_V : MAX_V) : wide[MSG_W-1:0];
  end

  // R7
  sat_range_chk: assert final (!(ovf && !wide[MSG_W]) || (sum_sat == MAX_V));
endmodule

// File: rtl/rowcmb_select.sv
module rowcmb_select
  import rowcmb_pkg::*;
#(
  parameter int OFFSET = 1
) (
  input  row_sum_t         summ,
  input  logic [MSG_W-1:0] t_val,
  input  logic             t_half,
  input  logic [POS_W-1:0] t_pos,
  output logic [MSG_W-1:0] r_new,
  output logic [MSG_W-1:0] q_new
);
  localparam logic [MAG_W-1:0] OFF_V = MAG_W'(OFFSET);

  logic             at_min;
  logic [MAG_W-1:0] pick;
  logic [MAG_W-1:0] mag;
  logic             neg;
  logic [MSG_W-1:0] pos_r;

  always_comb begin
    at_min = (t_half == summ.half) && (t_pos == summ.idx);
    pick   = at_min ? summ.m2 : summ.m1;
    mag    = (pick > OFF_V) ? (pick - OFF_V) : '0;
    neg    = summ.sgn ^ t_val[MSG_W-1];
    pos_r  = {1'b0, mag};
    r_new  = neg ? (MSG_W'(0) - pos_r) : pos_r;
  end

  rowcmb_satadd u_add (
    .op_a    (t_val),
    .op_b    (r_new),
    .sum_sat (q_new)
  );
endmodule

// File: rtl/split_row_combiner.sv
module split_row_combiner
  import rowcmb_pkg::*;
#(
  parameter int OFFSET = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_valid,
  output logic             row_ready,
  input  logic [MAG_W-1:0] a_m1,
  input  logic [MAG_W-1:0] a_m2,
  input  logic [POS_W-1:0] a_idx,
  input  logic             a_sign,
  input  logic [MAG_W-1:0] b_m1,
  input  logic [MAG_W-1:0] b_m2,
  input  logic [POS_W-1:0] b_idx,
  input  logic             b_sign,
  input  logic             elem_valid,
  output logic             elem_ready,
  input  logic [MSG_W-1:0] elem_t,
  input  logic             elem_half,
  input  logic [POS_W-1:0] elem_pos,
  input  logic             elem_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MSG_W-1:0] out_r,
  output logic [MSG_W-1:0] out_q,
  output logic             out_last
);
  row_sum_t         merged;
  row_sum_t         held;
  logic             row_loaded;
  logic             row_fire;
  logic             elem_fire;
  logic [MSG_W-1:0] r_calc;
  logic [MSG_W-1:0] q_calc;

  rowcmb_merge u_merge (
    .a_m1   (a_m1),
    .a_m2   (a_m2),
    .a_idx  (a_idx),
    .a_sign (a_sign),
    .b_m1   (b_m1),
    .b_m2   (b_m2),
    .b_idx  (b_idx),
    .b_sign (b_sign),
    .merged (merged)
  );

  rowcmb_select #(.OFFSET(OFFSET)) u_sel (
    .summ   (held),
    .t_val  (elem_t),
    .t_half (elem_half),
    .t_pos  (elem_pos),
    .r_new  (r_calc),
    .q_new  (q_calc)
  );

  assign row_ready  = ~row_loaded;
  assign row_fire   = row_valid & row_ready;
  assign elem_ready = row_loaded & (~out_valid | out_ready);
  assign elem_fire  = elem_valid & elem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_loaded <= 1'b0;
      held       <= '0;
    end else if (row_fire) begin
      row_loaded <= 1'b1;
      held       <= merged;
    end else if (elem_fire && elem_last) begin
      row_loaded <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_r     <= '0;
      out_q     <= '0;
      out_last  <= 1'b0;
    end else if (elem_fire) begin
      out_valid <= 1'b1;
      out_r     <= r_calc;
      out_q     <= q_calc;
      out_last  <= elem_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  no_elem_without_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_loaded |-> !elem_ready);

  // R2
  first_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_fire |=> (held.m1 <= $past(a_m1)) && (held.m1 <= $past(b_m1)));

  // R3
  second_min_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_fire && (a_m1 <= a_m2) && (b_m1 <= b_m2) |=> held.m1 <= held.m2);

  // R4
  sign_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_fire |=> held.sgn == ($past(a_sign) ^ $past(b_sign)));

  // R8
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_loaded && !(elem_fire && elem_last) |=> $stable(held) && !row_ready);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_r) && $stable(out_q) && $stable(out_last));
endmodule

// File: tb/tb_split_row_combiner.sv
`timescale 1ns/1ps
module tb_split_row_combiner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       row_valid = 1'b0;
  logic       row_ready;
  logic [3:0] a_m1 = '0, a_m2 = '0, b_m1 = '0, b_m2 = '0;
  logic [2:0] a_idx = '0, b_idx = '0;
  logic       a_sign = 1'b0, b_sign = 1'b0;
  logic       elem_valid = 1'b0;
  logic       elem_ready;
  logic [4:0] elem_t = '0;
  logic       elem_half = 1'b0;
  logic [2:0] elem_pos = '0;
  logic       elem_last = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [4:0] out_r, out_q;
  logic       out_last;

  int checks = 0;
  int failures = 0;
  int bp_mode = 0;
  int cyc = 0;
  bit finished = 0;

  int exp_r[$];
  int exp_q[$];
  int exp_l[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;

  split_row_combiner dut (
    .clk(clk), .rst_n(rst_n),
    .row_valid(row_valid), .row_ready(row_ready),
    .a_m1(a_m1), .a_m2(a_m2), .a_idx(a_idx), .a_sign(a_sign),
    .b_m1(b_m1), .b_m2(b_m2), .b_idx(b_idx), .b_sign(b_sign),
    .elem_valid(elem_valid), .elem_ready(elem_ready),
    .elem_t(elem_t), .elem_half(elem_half), .elem_pos(elem_pos), .elem_last(elem_last),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_q(out_q), .out_last(out_last)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model built from R2..R7: sort the four magnitudes.
  function automatic void model(input int t, input int h, input int p,
                                output int r, output int q);
    int v[4];
    int lo, nx, win_h, win_p, sgn, pick, mag, neg;
    v[0] = a_m1; v[1] = a_m2; v[2] = b_m1; v[3] = b_m2;
    lo = 99; nx = 99;
    for (int i = 0; i < 4; i++) begin
      if (v[i] < lo) begin nx = lo; lo = v[i]; end
      else if (v[i] < nx) nx = v[i];
    end
    win_h = (a_m1 <= b_m1) ? 0 : 1;
    win_p = (win_h == 0) ? int'(a_idx) : int'(b_idx);
    sgn   = a_sign ^ b_sign;
    pick  = (h == win_h && p == win_p) ? nx : lo;
    mag   = (pick > 1) ? pick - 1 : 0;
    neg   = sgn ^ ((t < 0) ? 1 : 0);
    r     = neg ? -mag : mag;
    q     = t + r;
    if (q > 15) q = 15;
    if (q < -16) q = -16;
  endfunction

  task automatic send_row(input int am1, input int am2, input int ai, input int as_,
                          input int bm1, input int bm2, input int bi, input int bs);
    @(negedge clk);
    elem_valid = 1'b0;
    row_valid = 1'b1;
    a_m1 = 4'(am1); a_m2 = 4'(am2); a_idx = 3'(ai); a_sign = 1'(as_);
    b_m1 = 4'(bm1); b_m2 = 4'(bm2); b_idx = 3'(bi); b_sign = 1'(bs);
    forever begin
      #1;
      if (row_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    @(negedge clk);
    row_valid = 1'b0;
  endtask

  task automatic send_elem(input int t, input int h, input int p, input int last, input string tag);
    int r, q;
    @(negedge clk);
    elem_valid = 1'b1;
    elem_t = 5'(t); elem_half = 1'(h); elem_pos = 3'(p); elem_last = 1'(last);
    forever begin
      #1;
      // R8: summary still held while its elements flow
      check(row_ready == 1'b0, "R8 row_ready low while row held", int'(row_ready), 0);
      if (elem_ready) begin
        model(t, h, p, r, q);
        exp_r.push_back(r); exp_q.push_back(q); exp_l.push_back(last); exp_tag.push_back(tag);
        @(posedge clk);
        break;
      end
      // R9: stall only because the output is blocked
      check(out_valid && !out_ready, "R9 elem_ready low only on output stall",
            int'(out_valid && !out_ready), 1);
      @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    out_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  // Monitor / scoreboard
  logic       held_v = 1'b0;
  logic [4:0] held_r, held_q;
  logic       held_l;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (held_v) begin
        // R9: held result unchanged
        check(out_valid && out_r == held_r && out_q == held_q && out_last == held_l,
              "R9 held output stable", int'(out_q), int'(held_q));
      end
      held_v = out_valid && !out_ready;
      held_r = out_r; held_q = out_q; held_l = out_last;
      if (out_valid && out_ready) begin
        if (exp_r.size() == 0) begin
          check(1'b0, "R10 unexpected result", 1, 0);
        end else begin
          int er, eq, el;
          string tg;
          er = exp_r.pop_front(); eq = exp_q.pop_front();
          el = exp_l.pop_front(); tg = exp_tag.pop_front();
          check(int'($signed(out_r)) == er, {tg, " R6 out_r"}, int'($signed(out_r)), er);
          check(int'($signed(out_q)) == eq, {tg, " R7 out_q"}, int'($signed(out_q)), eq);
          check(int'(out_last) == el, {tg, " R10 out_last"}, int'(out_last), el);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(elem_ready == 1'b0, "R1 elem_ready after reset", int'(elem_ready), 0);
    check(row_ready == 1'b1, "R1 row_ready after reset", int'(row_ready), 1);

    // R2 R3 R4 R5: half A wins, loser m1 below winner m2
    send_row(3, 7, 2, 0, 5, 6, 4, 1);
    send_elem(6, 0, 2, 0, "R5 at winner pos");
    send_elem(-5, 1, 4, 0, "R4 sign exclusion");
    send_elem(14, 1, 2, 1, "R5 half mismatch");

    // R2 R3 R7: half B wins, winner m2 smaller, saturation both rails
    send_row(9, 12, 5, 0, 2, 3, 5, 0);
    send_elem(15, 1, 5, 0, "R7 upper rail");
    send_elem(-16, 0, 5, 0, "R7 lower rail");
    send_elem(0, 1, 0, 1, "R3 winner m2");

    // R2 tie, R6 zero floor
    send_row(0, 1, 0, 1, 1, 15, 1, 0);
    send_elem(-7, 0, 0, 0, "R6 floor at m2");
    send_elem(9, 1, 1, 1, "R6 floor at m1");

    send_row(4, 9, 1, 1, 4, 5, 3, 1);
    send_elem(3, 0, 1, 0, "R2 tie A");
    send_elem(-3, 1, 3, 1, "R2 tie B");

    // Random rows with output back-pressure
    bp_mode = 1;
    for (int n = 0; n < 300; n++) begin
      int x1, x2, y1, y2, ne;
      x1 = $urandom_range(0, 15); x2 = $urandom_range(x1, 15);
      y1 = $urandom_range(0, 15); y2 = $urandom_range(y1, 15);
      send_row(x1, x2, $urandom_range(0, 7), $urandom_range(0, 1),
               y1, y2, $urandom_range(0, 7), $urandom_range(0, 1));
      ne = $urandom_range(1, 5);
      for (int e = 0; e < ne; e++)
        send_elem($urandom_range(0, 31) - 16, $urandom_range(0, 1), $urandom_range(0, 7),
                  (e == ne - 1) ? 1 : 0, "R5 random");
    end
    @(negedge clk);
    elem_valid = 1'b0;
    bp_mode = 0;
    repeat (20) @(negedge clk);
    check(exp_r.size() == 0, "R10 all results delivered", exp_r.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule